// File: doc/BRIEF.md
# Quadrature Encoder Counting Front End

This block sits in front of a general-purpose timer counter and turns two external encoder channels, A and B, into single up or down steps of a counter. Both channel inputs arrive already synchronized and filtered. A 4-bit mode code selects how the channels are decoded. The choices are quadrature decoding at x1, x2 or x4 resolution, clock-plus-direction decoding, and separate up and down clock channels. Per-channel polarity bits choose the active edge in the single-edge modes.

The counter runs between 0 and an auto-reload value. Counting up past the reload value wraps the counter to 0. Counting down past 0 reloads it with the reload value. Either wrap raises a one-cycle update pulse. A direction flag reports which way the most recent counted step went. Each channel's level is compared with its value one cycle earlier to find edges, so a step shows on the counter output one clock edge after the input change that caused it.

Top module: `qenc_front`

## Requirements
- R1: While `rst` is high, the block sets `count` to 0, `dir_down` to 0 and `update` to 0. The channel levels held during reset do not produce a step when reset is released.
- R2: Mode code 1 counts only on edges of A. A step goes up when the new level of A differs from the level of B, and down otherwise. Edges of B are ignored.
- R3: Mode code 2 counts only on edges of B. A step goes up when the new level of B equals the level of A, and down otherwise. Edges of A are ignored.
- R4: Mode code 3 counts on every edge of A (with the R2 rule) and of B (with the R3 rule). When A and B change in the same cycle, no step is made.
- R5: Mode code 14 counts only on the A edge selected by `pol_a`, using the R2 direction rule. Mode code 15 counts only on the B edge selected by `pol_b`, using the R3 direction rule. A polarity bit of 0 selects the rising edge and 1 selects the falling edge.
- R6: Mode code 10 counts on both edges of A. The level of B sets the direction: 0 counts up and 1 counts down.
- R7: Mode code 11 counts only on the A edge selected by `pol_a`, with the level of B setting the direction as in R6.
- R8: Mode code 12 counts up on both edges of A and down on both edges of B. When both channels change in the same cycle, no step is made.
- R9: Mode code 13 counts up on the A edge selected by `pol_a` and down on the B edge selected by `pol_b`. When both selected edges occur in the same cycle, no step is made.
- R10: An up step taken while `count` equals `reload` sets `count` to 0 and drives `update` high for exactly one cycle.
- R11: A down step taken while `count` is 0 sets `count` to `reload` and drives `update` high for exactly one cycle.
- R12: `dir_down` is 1 after a down step and 0 after an up step. It holds its value in cycles with no step.
- R13: Mode codes 0 and 4 to 9 make no steps. In those modes `count`, `dir_down` and `update` are unaffected by channel activity.
- R14: A step caused by an input change in one cycle appears on `count` after the next rising clock edge, and never earlier. Each step changes `count` by exactly one, apart from the wraps in R10 and R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a | input | 1 | Encoder channel A level (synchronized) |
| ch_b | input | 1 | Encoder channel B level (synchronized) |
| mode_sel | input | 4 | Decoding mode code |
| pol_a | input | 1 | Active edge of A in single-edge modes: 0 rising, 1 falling |
| pol_b | input | 1 | Active edge of B in single-edge modes: 0 rising, 1 falling |
| reload | input | CNT_W | Auto-reload value, the top of the count range |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | Direction of the last step: 1 down, 0 up |
| update | output | 1 | One-cycle pulse on a wrap in either direction |

## Verification
The hardest cases to reach from the ports are the coincident-edge cases in the x4 and up/down modes, and a wrap in each direction. A coincident edge needs both channels to change inside the same clock cycle. A wrap needs the counter to sit exactly on 0 or on the reload value. The stimulus drives both channels at the same clock low phase to produce a simultaneous change. It also starts from reset with a small reload value, so that four up edges and then one down edge hit both boundaries. The scoreboard compares the counter, the flag and the pulse on every cycle, so a missing pulse or a pulse that lasts one cycle too long is caught.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [3:0] {
        MODE_QUAD_A  = 4'd1,
        MODE_QUAD_B  = 4'd2,
        MODE_QUAD_AB = 4'd3,
        MODE_CDIR_X2 = 4'd10,
        MODE_CDIR_X1 = 4'd11,
        MODE_UPDN_X2 = 4'd12,
        MODE_UPDN_X1 = 4'd13,
        MODE_X1_A    = 4'd14,
        MODE_X1_B    = 4'd15
    } mode_e;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } chan_ev_t;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    function automatic logic mode_counts(input logic [3:0] m);
        return (m >= 4'd1 && m <= 4'd3) || (m >= 4'd10);
    endfunction

    function automatic logic edge_pick(input chan_ev_t ev, input logic pol);
        return pol ? ev.fall : ev.rise;
    endfunction

endpackage

// File: rtl/qenc_edge.sv
module qenc_edge
    import qenc_pkg::*;
(
    input  logic     clk,
    input  logic     lvl_i,
    output chan_ev_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    always_comb begin
        ev_o.lvl  = lvl_i;
        ev_o.rise = lvl_i & ~prev_q;
        ev_o.fall = ~lvl_i & prev_q;
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic [3:0] mode_i,
    input  logic       pol_a_i,
    input  logic       pol_b_i,
    input  chan_ev_t   ev_a_i,
    input  chan_ev_t   ev_b_i,
    output step_t      step_o
);
    logic any_a, any_b, sel_a, sel_b, quad_a_up, quad_b_up;

    always_comb begin
        any_a     = ev_a_i.rise | ev_a_i.fall;
        any_b     = ev_b_i.rise | ev_b_i.fall;
        sel_a     = edge_pick(ev_a_i, pol_a_i);
        sel_b     = edge_pick(ev_b_i, pol_b_i);
        quad_a_up = ev_a_i.lvl ^ ev_b_i.lvl;
        quad_b_up = ~(ev_a_i.lvl ^ ev_b_i.lvl);
        step_o    = '0;
        case (mode_i)
            MODE_QUAD_A: if (any_a) begin
                step_o.up = quad_a_up;
                step_o.dn = ~quad_a_up;
            end
            MODE_QUAD_B: if (any_b) begin
                step_o.up = quad_b_up;
                step_o.dn = ~quad_b_up;
            end
            MODE_QUAD_AB: begin
                if (any_a && !any_b) begin
                    step_o.up = quad_a_up;
                    step_o.dn = ~quad_a_up;
                end else if (any_b && !any_a) begin
                    step_o.up = quad_b_up;
                    step_o.dn = ~quad_b_up;
                end
            end
            MODE_X1_A: if (sel_a) begin
                step_o.up = quad_a_up;
                step_o.dn = ~quad_a_up;
            end
            MODE_X1_B: if (sel_b) begin
                step_o.up = quad_b_up;
                step_o.dn = ~quad_b_up;
            end
            MODE_CDIR_X2: if (any_a) begin
                step_o.up = ~ev_b_i.lvl;
                step_o.dn = ev_b_i.lvl;
            end
            MODE_CDIR_X1: if (sel_a) begin
                step_o.up = ~ev_b_i.lvl;
                step_o.dn = ev_b_i.lvl;
            end
            MODE_UPDN_X2: begin
                step_o.up = any_a & ~any_b;
                step_o.dn = any_b & ~any_a;
            end
            MODE_UPDN_X1: begin
                step_o.up = sel_a & ~sel_b;
                step_o.dn = sel_b & ~sel_a;
            end
            default: step_o = '0;
        endcase
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             update_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o    <= '0;
            dir_down_o <= 1'b0;
            update_o   <= 1'b0;
        end else begin
            update_o <= 1'b0;
            if (step_i.up) begin
                dir_down_o <= 1'b0;
                if (count_o == reload_i) begin
                    count_o  <= '0;
                    update_o <= 1'b1;
                end else begin
                    count_o <= count_o + ONE;
                end
            end else if (step_i.dn) begin
                dir_down_o <= 1'b1;
                if (count_o == '0) begin
                    count_o  <= reload_i;
                    update_o <= 1'b1;
                end else begin
                    count_o <= count_o - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/qenc_front.sv
module qenc_front
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic [3:0]       mode_sel,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             update
);
    logic [NUM_CH-1:0] ch_lvl;
    chan_ev_t          ch_ev [NUM_CH];
    step_t             step;

    assign ch_lvl = {ch_b, ch_a};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_edge
        qenc_edge u_edge (
            .clk   (clk),
            .lvl_i (ch_lvl[i]),
            .ev_o  (ch_ev[i])
        );
    end

    qenc_decode u_decode (
        .mode_i  (mode_sel),
        .pol_a_i (pol_a),
        .pol_b_i (pol_b),
        .ev_a_i  (ch_ev[CH_A]),
        .ev_b_i  (ch_ev[CH_B]),
        .step_o  (step)
    );

    qenc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .reload_i   (reload),
        .count_o    (count),
        .dir_down_o (dir_down),
        .update_o   (update)
    );
endmodule

// File: rtl/qenc_front_chk.sv
module qenc_front_chk
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       mode_sel,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             update
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !dir_down && !update));

    assert_unit_step_R14: assert property (@(posedge clk) disable iff (rst)
        (!update && count != $past(count)) |->
        (count == $past(count) + CNT_W'(1) || count == $past(count) - CNT_W'(1)));

    assert_wrap_up_R10: assert property (@(posedge clk) disable iff (rst)
        (update && !dir_down) |-> count == '0);

    assert_wrap_down_R11: assert property (@(posedge clk) disable iff (rst)
        (update && dir_down) |-> count == $past(reload));

    assert_idle_mode_R13: assert property (@(posedge clk) disable iff (rst)
        !mode_counts(mode_sel) |=> ($stable(count) && !update));

    assert_dir_hold_R12: assert property (@(posedge clk) disable iff (rst)
        ($stable(count) && !update) |-> $stable(dir_down));
endmodule

bind qenc_front qenc_front_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .reload   (reload),
    .count    (count),
    .dir_down (dir_down),
    .update   (update)
);

// File: tb/qenc_front_bench.sv
module qenc_front_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ch_a = 1'b1, ch_b = 1'b0;
    logic [3:0]   mode_sel = 4'd0;
    logic         pol_a = 1'b0, pol_b = 1'b0;
    logic [W-1:0] reload = W'(3);
    logic [W-1:0] count;
    logic         dir_down, update;

    always #4 clk = ~clk;

    qenc_front #(.CNT_W(W)) u_qenc_front (
        .clk(clk), .rst(rst), .ch_a(ch_a), .ch_b(ch_b), .mode_sel(mode_sel),
        .pol_a(pol_a), .pol_b(pol_b), .reload(reload),
        .count(count), .dir_down(dir_down), .update(update)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         dir;
        logic         upd;
        string        tag;
    } exp_t;

    exp_t         sb_q [$];
    int           n_checks = 0, n_fail = 0;
    bit           done = 0;
    logic [W-1:0] m_cnt = '0;
    logic         m_dir = 0, m_upd = 0, pa = 1, pb = 0;

    function automatic int model_dir(input logic a, input logic b);
        logic ea, eb, sa, sb;
        int   v;
        ea = (a != pa);
        eb = (b != pb);
        sa = pol_a ? (pa && !a) : (a && !pa);
        sb = pol_b ? (pb && !b) : (b && !pb);
        v  = 0;
        case (mode_sel)
            4'd1:  if (ea) v = (a != b) ? 1 : -1;
            4'd2:  if (eb) v = (a == b) ? 1 : -1;
            4'd3:  if (ea && !eb) v = (a != b) ? 1 : -1;
                   else if (eb && !ea) v = (a == b) ? 1 : -1;
            4'd14: if (sa) v = (a != b) ? 1 : -1;
            4'd15: if (sb) v = (a == b) ? 1 : -1;
            4'd10: if (ea) v = b ? -1 : 1;
            4'd11: if (sa) v = b ? -1 : 1;
            4'd12: if (ea && !eb) v = 1; else if (eb && !ea) v = -1;
            4'd13: if (sa && !sb) v = 1; else if (sb && !sa) v = -1;
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic push_model(input logic a, input logic b, input string tag);
        int   v;
        exp_t e;
        v = model_dir(a, b);
        m_upd = 0;
        if (v == 1) begin
            m_dir = 0;
            if (m_cnt == reload) begin m_cnt = '0; m_upd = 1; end
            else m_cnt = m_cnt + W'(1);
        end else if (v == -1) begin
            m_dir = 1;
            if (m_cnt == '0) begin m_cnt = reload; m_upd = 1; end
            else m_cnt = m_cnt - W'(1);
        end
        pa = a;
        pb = b;
        e.cnt = m_cnt; e.dir = m_dir; e.upd = m_upd; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drive(input logic a, input logic b, input string tag);
        @(negedge clk);
        ch_a = a;
        ch_b = b;
        push_model(a, b, tag);
    endtask

    task automatic cfg(input logic [3:0] m, input logic p_a, input logic p_b, input string tag);
        @(negedge clk);
        mode_sel = m;
        pol_a    = p_a;
        pol_b    = p_b;
        push_model(ch_a, ch_b, tag);
    endtask

    task automatic quad_fwd(input string tag);
        drive(1, 0, tag); drive(1, 1, tag); drive(0, 1, tag); drive(0, 0, tag);
    endtask

    task automatic quad_rev(input string tag);
        drive(0, 1, tag); drive(1, 1, tag); drive(1, 0, tag); drive(0, 0, tag);
    endtask

    task automatic check(input bit ok, input string tag, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Monitor: pops one expected item per cycle, after the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(count == e.cnt && dir_down == e.dir && update == e.upd, e.tag,
                      $sformatf("actual cnt=%0d dir=%0b upd=%0b expected cnt=%0d dir=%0b upd=%0b",
                                count, dir_down, update, e.cnt, e.dir, e.upd));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R14 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        check(count == '0 && !dir_down && !update, "R1",
              $sformatf("actual cnt=%0d dir=%0b upd=%0b expected 0/0/0", count, dir_down, update));
        // R1: levels held over reset give no step
        cfg(4'd3, 0, 0, "R1");
        drive(1, 0, "R1");

        // R10: four up steps with reload 3 wrap to 0 with a pulse
        cfg(4'd12, 0, 0, "R10");
        drive(0, 0, "R10"); drive(1, 0, "R10"); drive(0, 0, "R10"); drive(1, 0, "R10");
        drive(1, 0, "R10");
        // R11: down from 0 reloads
        drive(1, 1, "R11");
        drive(1, 1, "R11");
        @(negedge clk);
        reload = W'(1000);
        push_model(ch_a, ch_b, "R11");

        // R14: count unchanged before the clock edge after the input change
        drive(0, 0, "R8");
        @(negedge clk);
        ch_a = 1;
        #1;
        check(count == m_cnt, "R14",
              $sformatf("actual cnt=%0d expected cnt=%0d before edge", count, m_cnt));
        push_model(1, 0, "R14");
        drive(0, 1, "R8");          // simultaneous change in mode 12
        drive(0, 0, "R8");

        cfg(4'd1, 0, 0, "R2");
        quad_fwd("R2"); quad_rev("R2"); quad_rev("R2");
        cfg(4'd2, 0, 0, "R3");
        quad_fwd("R3"); quad_fwd("R3"); quad_rev("R3");
        cfg(4'd3, 0, 0, "R4");
        quad_fwd("R4"); quad_fwd("R4"); quad_rev("R4");
        drive(1, 1, "R4"); drive(0, 0, "R4");

        cfg(4'd14, 0, 0, "R5");
        quad_fwd("R5"); quad_rev("R5");
        cfg(4'd14, 1, 0, "R5");
        quad_fwd("R5"); quad_fwd("R5");
        cfg(4'd15, 0, 1, "R5");
        quad_fwd("R5"); quad_rev("R5"); quad_rev("R5");

        cfg(4'd10, 0, 0, "R6");
        drive(1, 0, "R6"); drive(0, 0, "R6"); drive(0, 1, "R6"); drive(1, 1, "R6");
        drive(0, 1, "R6"); drive(0, 0, "R6");
        cfg(4'd11, 0, 0, "R7");
        drive(1, 0, "R7"); drive(0, 0, "R7"); drive(1, 0, "R7"); drive(0, 1, "R7");
        drive(1, 1, "R7");
        cfg(4'd11, 1, 0, "R7");
        drive(0, 1, "R7"); drive(0, 0, "R7"); drive(1, 0, "R7"); drive(0, 0, "R7");

        cfg(4'd13, 0, 0, "R9");
        drive(1, 0, "R9"); drive(0, 0, "R9"); drive(0, 1, "R9"); drive(0, 0, "R9");
        drive(1, 1, "R9");
        cfg(4'd13, 1, 1, "R9");
        drive(0, 0, "R9"); drive(0, 1, "R9"); drive(0, 0, "R9");

        // R12: up step, then idle-mode activity leaves direction and count
        cfg(4'd12, 0, 0, "R12");
        drive(1, 0, "R12");
        foreach (sb_q[i]) begin end
        cfg(4'd0, 0, 0, "R13");
        drive(0, 1, "R13"); drive(1, 0, "R13"); drive(0, 0, "R12");
        cfg(4'd5, 0, 0, "R13");
        quad_fwd("R13"); quad_rev("R13");
        cfg(4'd7, 0, 0, "R13");
        drive(1, 1, "R13"); drive(0, 0, "R12");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule